// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is a memory-mapped host controller that issues byte-wide LPC I/O cycles for a CPU. Software sets a burst length, a command word and a 16-bit port address. For writes it queues the outgoing bytes, then sets the start bit. The engine runs the whole burst on the LAD/LFRAME# pins without further software help, one byte per cycle. It waits as long as the peripheral asks through SYNC wait codes. Bytes that come back from reads are placed in a queue.

Completion is reported by two status bits, idle and finished-OK. A completion flag, cleared by writing 1 to it, can raise an interrupt. The command word picks read or write, and picks between one fixed port for every cycle of the burst or a port that steps by one after each cycle. The block runs in the LPC clock domain.

Top module: `lpc_io_engine`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x0001 (bit 0 idle set, bit 1 finished-OK clear), the interrupt register reads 0, LFRAME# (`lframe_no`) is high and `lad_oe_o` is low.
- R2: Writing 1 to bit 0 of offset 0x00 while idle starts a burst. From the next clock `lframe_no` is low for exactly one clock, with LAD = 0000, at the start of each byte cycle, and status bit 0 reads 0 until the burst ends.
- R3: After the START nibble the host drives the cycle-type/direction nibble (0010 for an I/O write, 0000 for an I/O read), then the 16-bit port address as four nibbles, most significant first. On writes it then drives the data byte, low nibble first.
- R4: Command register (0x14) bit 0 selects write (1) or read (0). If bit 3 is set, every cycle of the burst uses the address from 0x20. If bit 3 is clear, the address rises by one per cycle.
- R5: Offset 0x10 sets the number of byte cycles per start (1 to 16). On a write burst, cycle n sends the n-th byte pushed through bits 7:0 of offset 0x24.
- R6: On a read burst, the two nibbles that follow a ready SYNC (low nibble first) form one byte in the read queue. Each read of offset 0x28 returns the next byte in bits 7:0 and removes it. An empty queue reads 0. A start clears any bytes left in the queue.
- R7: SYNC 0101 or 0110 keeps the cycle waiting. Up to SYNC_LIMIT (300) wait nibbles per cycle are tolerated, and the cycle then completes normally.
- R8: SYNC 1010, or any code other than ready or wait, ends the burst at once. No further cycles start, and status reads 0x0001.
- R9: A cycle that receives more than SYNC_LIMIT wait nibbles ends the burst the same way as an error.
- R10: A burst whose cycles all end with ready SYNC leaves status at 0x0003.
- R11: Interrupt register (0x08) bit 0 is an enable. Bit 1 is set only by a successful burst end and is cleared by writing 1 to it. `irq_o` is high when both bits are set.
- R12: While a burst runs, writes to offsets 0x10, 0x14, 0x20 and 0x24 and a repeated start have no effect.
- R13: After the data phase (write) or the address phase (read) the host drives 1111 for one clock, then releases LAD before SYNC. The write queue is emptied when each burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | LPC clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the read queue at 0x28) |
| reg_addr_i | input | 12 | Byte offset within the register window |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Completion interrupt |
| lframe_no | output | 1 | Active-low cycle framing |
| lad_o | output | 4 | Host-driven LAD nibble |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD nibble from the bus |

## Verification
The bench plays the peripheral, records every nibble the host drives, and checks the recorded sequence. A wrong nibble order or a missed address increment shows up as a wrong recorded address or byte. The bench runs 256 wait nibbles to catch a wait counter that is too narrow, because such a counter aborts a legal slow cycle. It also runs 400 wait nibbles to catch a missing timeout, because without one the engine hangs forever. It injects an error SYNC partway through a burst to expose an engine that keeps going or still reports success. It rewrites the configuration while a burst is running to expose registers that accept writes while busy. A leftover byte from the aborted burst would be sent on the next write if the write queue were not emptied, and the bench checks for that.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  localparam logic [11:0] OFS_GO   = 12'h000;
  localparam logic [11:0] OFS_STAT = 12'h004;
  localparam logic [11:0] OFS_IRQ  = 12'h008;
  localparam logic [11:0] OFS_LEN  = 12'h010;
  localparam logic [11:0] OFS_CMD  = 12'h014;
  localparam logic [11:0] OFS_ADDR = 12'h020;
  localparam logic [11:0] OFS_WDAT = 12'h024;
  localparam logic [11:0] OFS_RDAT = 12'h028;

  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTDIR, S_ADDR, S_WDAT,
    S_TAR1, S_TAR2, S_SYNC, S_RDAT, S_TAR3, S_TAR4
  } seq_state_e;
endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] count_q;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign data_o  = empty_o ? '0 : mem_q[rp_q];

  wire do_push = push_i && !full_o;
  wire do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0; wp_q <= '0; count_q <= '0;
    end else if (flush_i) begin
      rp_q <= '0; wp_q <= '0; count_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= data_i;
  end

  // R5 R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_BURST  = 16,
  parameter int SYNC_LIMIT = 300,
  localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              wr_i,
  input  logic              same_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [7:0]        wbyte_i,
  output logic              wpop_o,
  output logic              rpush_o,
  output logic [7:0]        rbyte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              lframe_no,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [3:0]        lad_i
);
  localparam int NIBS = ADDR_W / 4;
  localparam int NW   = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam int WCW  = $clog2(SYNC_LIMIT + 1);

  seq_state_e        state_q;
  logic [NW-1:0]     nib_q;
  logic              hi_q, wr_q, same_q, done_q, ok_q;
  logic [LEN_W-1:0]  left_q, len_eff;
  logic [ADDR_W-1:0] cur_q;
  logic [7:0]        wbyte_q;
  logic [3:0]        lo_q;
  logic [WCW-1:0]    wcnt_q;

  assign len_eff = (len_i == '0) ? LEN_W'(1) :
                   (len_i > LEN_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; nib_q <= '0; hi_q <= 1'b0; wr_q <= 1'b0;
      same_q <= 1'b0; done_q <= 1'b0; ok_q <= 1'b0; left_q <= '0;
      cur_q <= '0; wbyte_q <= '0; lo_q <= '0; wcnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go_i) begin
          state_q <= S_START; left_q <= len_eff; cur_q <= base_i;
          wr_q <= wr_i; same_q <= same_i; ok_q <= 1'b0;
        end
        S_START: state_q <= S_CTDIR;
        S_CTDIR: begin state_q <= S_ADDR; nib_q <= NW'(NIBS - 1); end
        S_ADDR: if (nib_q == '0) begin
          if (wr_q) begin state_q <= S_WDAT; wbyte_q <= wbyte_i; end
          else state_q <= S_TAR1;
        end else nib_q <= nib_q - 1'b1;
        S_WDAT: begin hi_q <= !hi_q; if (hi_q) state_q <= S_TAR1; end
        S_TAR1: state_q <= S_TAR2;
        S_TAR2: begin state_q <= S_SYNC; wcnt_q <= '0; end
        S_SYNC: begin
          if (lad_i == SYNC_READY) state_q <= wr_q ? S_TAR3 : S_RDAT;
          else if ((lad_i == SYNC_SHORT || lad_i == SYNC_LONG) &&
                   wcnt_q != WCW'(SYNC_LIMIT)) wcnt_q <= wcnt_q + 1'b1;
          else begin state_q <= S_IDLE; done_q <= 1'b1; ok_q <= 1'b0; end
        end
        S_RDAT: begin
          hi_q <= !hi_q;
          if (hi_q) state_q <= S_TAR3; else lo_q <= lad_i;
        end
        S_TAR3: state_q <= S_TAR4;
        S_TAR4: if (left_q == LEN_W'(1)) begin
          state_q <= S_IDLE; done_q <= 1'b1; ok_q <= 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
          if (!same_q) cur_q <= cur_q + 1'b1;
          state_q <= S_START;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    lad_o = 4'hF;
    unique case (state_q)
      S_START: lad_o = 4'h0;
      S_CTDIR: lad_o = {2'b00, wr_q, 1'b0};
      S_ADDR:  lad_o = cur_q[{nib_q, 2'b00} +: 4];
      S_WDAT:  lad_o = hi_q ? wbyte_q[7:4] : wbyte_q[3:0];
      default: lad_o = 4'hF;
    endcase
  end

  assign lframe_no = (state_q != S_START);
  assign lad_oe_o  = state_q inside {S_START, S_CTDIR, S_ADDR, S_WDAT, S_TAR1};
  assign wpop_o    = (state_q == S_ADDR) && (nib_q == '0) && wr_q;
  assign rpush_o   = (state_q == S_RDAT) && hi_q;
  assign rbyte_o   = {lad_i, lo_q};
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign ok_o      = ok_q;

  // R2
  go_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_o |=> !lframe_no);
  // R2
  frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |=> lframe_no);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WCW'(SYNC_LIMIT));
endmodule

// File: rtl/lpc_io_engine.sv
module lpc_io_engine
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_BURST  = 16,
  parameter int SYNC_LIMIT = 300,
  localparam int REG_W     = ADDR_W,
  localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [11:0]      reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             lframe_no,
  output logic [3:0]       lad_o,
  output logic             lad_oe_o,
  input  logic [3:0]       lad_i
);
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic cmd_wr_q, cmd_same_q, irq_en_q, irq_st_q;
  logic busy, done, ok, wpop, rpush, go;
  logic [7:0] wbyte, rbyte, rhead;
  logic wq_empty, wq_full, rq_empty, rq_full;

  wire cfg_we = reg_we_i && !busy;
  assign go = cfg_we && (reg_addr_i == OFS_GO) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= LEN_W'(1); addr_q <= '0; cmd_wr_q <= 1'b0; cmd_same_q <= 1'b0;
      irq_en_q <= 1'b0; irq_st_q <= 1'b0;
    end else begin
      if (cfg_we && reg_addr_i == OFS_LEN)  len_q <= reg_wdata_i[LEN_W-1:0];
      if (cfg_we && reg_addr_i == OFS_ADDR) addr_q <= reg_wdata_i;
      if (cfg_we && reg_addr_i == OFS_CMD) begin
        cmd_wr_q   <= reg_wdata_i[0];
        cmd_same_q <= reg_wdata_i[3];
      end
      if (reg_we_i && reg_addr_i == OFS_IRQ) irq_en_q <= reg_wdata_i[0];
      if (done && ok) irq_st_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFS_IRQ && reg_wdata_i[1]) irq_st_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_STAT: reg_rdata_o = REG_W'({ok, !busy});
      OFS_IRQ:  reg_rdata_o = REG_W'({irq_st_q, irq_en_q});
      OFS_LEN:  reg_rdata_o = REG_W'(len_q);
      OFS_CMD:  reg_rdata_o = REG_W'({cmd_same_q, 2'b00, cmd_wr_q});
      OFS_ADDR: reg_rdata_o = addr_q;
      OFS_RDAT: reg_rdata_o = REG_W'(rhead);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_en_q && irq_st_q;

  lpc_byte_fifo #(.DEPTH(MAX_BURST), .W(8)) u_wq (
    .clk_i, .rst_ni, .flush_i(done),
    .push_i(cfg_we && reg_addr_i == OFS_WDAT), .data_i(reg_wdata_i[7:0]),
    .pop_i(wpop), .data_o(wbyte), .empty_o(wq_empty), .full_o(wq_full));

  lpc_byte_fifo #(.DEPTH(MAX_BURST), .W(8)) u_rq (
    .clk_i, .rst_ni, .flush_i(go),
    .push_i(rpush), .data_i(rbyte),
    .pop_i(reg_re_i && reg_addr_i == OFS_RDAT), .data_o(rhead),
    .empty_o(rq_empty), .full_o(rq_full));

  lpc_cycle_seq #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .SYNC_LIMIT(SYNC_LIMIT)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .wr_i(cmd_wr_q), .same_i(cmd_same_q),
    .len_i(len_q), .base_i(addr_q), .wbyte_i(wbyte), .wpop_o(wpop),
    .rpush_o(rpush), .rbyte_o(rbyte), .busy_o(busy), .done_o(done), .ok_o(ok),
    .lframe_no, .lad_o, .lad_oe_o, .lad_i);

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(len_q) && $stable(addr_q) && $stable(cmd_wr_q) && $stable(cmd_same_q));
  // R6
  read_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpush |-> !cmd_wr_q && !rq_full);
  // R13
  wq_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> wq_empty && !wq_full);
  // R11
  irq_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_st_q && !rq_empty | irq_st_q);
endmodule

// File: tb/lpc_io_engine_tb.sv
`timescale 1ns/1ps
module lpc_io_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, lframe_no, lad_oe_o;
  logic [3:0] lad_o, lad_in;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  lpc_io_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .lframe_no(lframe_no), .lad_o(lad_o), .lad_oe_o(lad_oe_o), .lad_i(lad_in));

  // peripheral model state
  logic [3:0]  cap_ct [16];
  logic [15:0] cap_ad [16];
  logic [7:0]  cap_wd [16];
  int          sw [16];
  logic [3:0]  sf [16];
  logic [7:0]  rdv [16];
  int cap_n = 0, tar_bad = 0, pidx;
  bit per_busy = 0, pwr;
  logic [15:0] pa;
  logic [7:0]  pd;

  initial begin
    lad_in = 4'hF;
    forever begin
      @(negedge clk);
      if (rst_n && !lframe_no) begin
        per_busy = 1; pidx = (cap_n < 16) ? cap_n : 15;
        @(negedge clk); cap_ct[pidx] = lad_o; pwr = lad_o[1];
        pa = '0;
        for (int k = 0; k < 4; k++) begin @(negedge clk); pa = {pa[11:0], lad_o}; end
        cap_ad[pidx] = pa;
        if (pwr) begin
          @(negedge clk); pd[3:0] = lad_o;
          @(negedge clk); pd[7:4] = lad_o;
          cap_wd[pidx] = pd;
        end
        @(negedge clk); if (!(lad_oe_o && lad_o == 4'hF)) tar_bad++;
        @(negedge clk); if (lad_oe_o) tar_bad++;
        cap_n++;
        for (int k = 0; k < sw[pidx]; k++) begin @(negedge clk); lad_in = 4'h6; end
        @(negedge clk); lad_in = sf[pidx];
        if (sf[pidx] == 4'h0) begin
          if (!pwr) begin
            @(negedge clk); lad_in = rdv[pidx][3:0];
            @(negedge clk); lad_in = rdv[pidx][7:4];
          end
          @(negedge clk); lad_in = 4'hF;
          @(negedge clk); lad_in = 4'hF;
        end else begin
          @(negedge clk); lad_in = 4'hF;
        end
        per_busy = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic clr_per();
    cap_n = 0; tar_bad = 0;
    for (int i = 0; i < 16; i++) begin sw[i] = 0; sf[i] = 4'h0; rdv[i] = '0; end
  endtask

  task automatic wait_done();
    logic [15:0] v;
    do reg_read(12'h004, v); while (!v[0]);
    while (per_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    #1;
    chk(lframe_no === 1'b1 && lad_oe_o === 1'b0, "R1 pins", {lframe_no, lad_oe_o}, 2'b10);
    reg_read(12'h004, v); chk(v == 16'h0001, "R1 status", v, 1);
    reg_read(12'h008, v); chk(v == 16'h0000, "R1 irq reg", v, 0);
  endtask

  task automatic t_write_incr();
    logic [15:0] v;
    clr_per();
    reg_write(12'h010, 3); reg_write(12'h014, 16'h0001); reg_write(12'h020, 16'h02E4);
    reg_write(12'h024, 16'h00AA); reg_write(12'h024, 16'h0055); reg_write(12'h024, 16'h00C3);
    reg_write(12'h000, 1);
    chk(lframe_no === 1'b0, "R2 frame after start", lframe_no, 0);
    reg_read(12'h004, v); chk(v[0] == 1'b0, "R2 busy status", v, 0);
    wait_done();
    reg_read(12'h004, v); chk(v == 16'h0003, "R10 ok status", v, 3);
    chk(cap_n == 3, "R5 cycle count", cap_n, 3);
    chk(cap_ct[0] == 4'h2, "R3 write ctdir", cap_ct[0], 2);
    chk(cap_ad[0] == 16'h02E4 && cap_ad[2] == 16'h02E6, "R4 incr addr", cap_ad[2], 16'h02E6);
    chk(cap_wd[0] == 8'hAA && cap_wd[1] == 8'h55 && cap_wd[2] == 8'hC3, "R5 write bytes", cap_wd[2], 8'hC3);
    chk(tar_bad == 0, "R13 turnaround", tar_bad, 0);
    reg_read(12'h008, v); chk(v[1] == 1'b1, "R11 done flag", v, 2);
  endtask

  task automatic t_read_fixed();
    logic [15:0] v;
    clr_per();
    for (int i = 0; i < 4; i++) begin sw[i] = 2; rdv[i] = 8'(8'h11 * (i + 1)); end
    reg_write(12'h010, 4); reg_write(12'h014, 16'h0008); reg_write(12'h020, 16'h0060);
    reg_write(12'h000, 1);
    wait_done();
    chk(cap_ct[0] == 4'h0, "R3 read ctdir", cap_ct[0], 0);
    chk(cap_ad[0] == 16'h0060 && cap_ad[3] == 16'h0060, "R4 fixed addr", cap_ad[3], 16'h0060);
    chk(tar_bad == 0, "R13 read turnaround", tar_bad, 0);
    for (int i = 0; i < 4; i++) begin
      reg_read(12'h028, v); chk(v == 16'(8'h11 * (i + 1)), "R6 read byte", v, 8'h11 * (i + 1));
    end
    reg_read(12'h028, v); chk(v == 0, "R6 empty queue", v, 0);
  endtask

  task automatic t_long_wait();
    logic [15:0] v;
    clr_per(); rdv[0] = 8'h3C; rdv[1] = 8'h4D;
    reg_write(12'h010, 2); reg_write(12'h014, 16'h0000); reg_write(12'h000, 1);
    wait_done();
    reg_read(12'h028, v);
    clr_per(); sw[0] = 256; rdv[0] = 8'h9E;
    reg_write(12'h010, 1); reg_write(12'h000, 1);
    wait_done();
    reg_read(12'h004, v); chk(v == 16'h0003, "R7 long wait ok", v, 3);
    reg_read(12'h028, v); chk(v == 16'h009E, "R6 start clears queue", v, 16'h9E);
    reg_read(12'h028, v); chk(v == 0, "R6 queue then empty", v, 0);
  endtask

  task automatic t_sync_error();
    logic [15:0] v;
    reg_write(12'h008, 16'h0002);
    clr_per(); sf[1] = 4'hA;
    reg_write(12'h010, 3); reg_write(12'h014, 16'h0001);
    reg_write(12'h024, 16'h0001); reg_write(12'h024, 16'h0002); reg_write(12'h024, 16'h0003);
    reg_write(12'h000, 1);
    wait_done();
    repeat (20) @(negedge clk);
    reg_read(12'h004, v); chk(v == 16'h0001, "R8 error status", v, 1);
    chk(cap_n == 2, "R8 burst stopped", cap_n, 2);
    reg_read(12'h008, v); chk(v[1] == 1'b0, "R11 no flag on error", v, 0);
    clr_per();
    reg_write(12'h010, 1); reg_write(12'h024, 16'h0077); reg_write(12'h000, 1);
    wait_done();
    chk(cap_wd[0] == 8'h77, "R13 write queue emptied", cap_wd[0], 8'h77);
  endtask

  task automatic t_timeout();
    logic [15:0] v;
    clr_per(); sw[0] = 400;
    reg_write(12'h010, 1); reg_write(12'h014, 16'h0000); reg_write(12'h000, 1);
    wait_done();
    reg_read(12'h004, v); chk(v == 16'h0001, "R9 timeout error", v, 1);
    chk(cap_n == 1, "R9 single cycle", cap_n, 1);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    clr_per(); sw[0] = 20; sw[1] = 20;
    reg_write(12'h010, 2); reg_write(12'h014, 16'h0001); reg_write(12'h020, 16'h0100);
    reg_write(12'h024, 16'h0011); reg_write(12'h024, 16'h0022);
    reg_write(12'h000, 1);
    reg_write(12'h010, 5); reg_write(12'h014, 16'h0008); reg_write(12'h020, 16'h1234);
    reg_write(12'h024, 16'h0099); reg_write(12'h000, 1);
    wait_done();
    repeat (20) @(negedge clk);
    chk(cap_n == 2, "R12 no extra cycles", cap_n, 2);
    reg_read(12'h010, v); chk(v == 2, "R12 length held", v, 2);
    reg_read(12'h014, v); chk(v == 16'h0001, "R12 command held", v, 1);
    reg_read(12'h020, v); chk(v == 16'h0100, "R12 address held", v, 16'h0100);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    reg_write(12'h008, 16'h0001);
    #1 chk(irq === 1'b1, "R11 irq asserted", irq, 1);
    reg_write(12'h008, 16'h0001);
    #1 chk(irq === 1'b1, "R11 write 0 keeps flag", irq, 1);
    reg_write(12'h008, 16'h0003);
    #1 chk(irq === 1'b0, "R11 w1c clears", irq, 0);
    reg_read(12'h008, v); chk(v == 16'h0001, "R11 reg after clear", v, 1);
  endtask

  initial begin
    clr_per();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_incr();
    t_read_fixed();
    t_long_wait();
    t_sync_error();
    t_timeout();
    t_busy_ignore();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule